// File: doc/BRIEF.md
# Carry-Select Adder Segment with Decoded Select

This block adds one slice of a wider binary adder. It runs two ripple-carry adders side by side over the same operand slice. One assumes the incoming carry is 0 and the other assumes it is 1. Each adder has its assumed carry built into its lowest bit, so neither adder has a carry input. A single 2:1 multiplexer then passes one of the two results, sum and carry-out together, to the outputs.

The block sits above a lower slice whose two conditional carry-outs are already computed. `cc_lo` is the lower slice's carry-out for a carry-in of 0, and `cc_hi` is its carry-out for a carry-in of 1. `seg_cin` is the carry into that lower slice. A three-input decoder turns these three signals into the multiplexer select, so the real carry into this slice never passes through a chain of multiplexers.

For a plain carry-select stage, tie `cc_lo` to 0 and `cc_hi` to 1; the select is then `seg_cin` itself. Where a system ties the select to a constant, the `SEL_MODE` parameter builds only the one adder that can be chosen, with no multiplexer.

Top module: `csel_segment`

## Requirements
- R1: In dynamic mode, {seg_cout, seg_sum} equals opa + opb + k, where k = cc_hi when seg_cin is 1 and k = cc_lo when seg_cin is 0.
- R2: With seg_cin = 0, cc_hi has no effect on the outputs: they equal opa + opb + cc_lo.
- R3: With seg_cin = 1, cc_lo has no effect on the outputs: they equal opa + opb + cc_hi.
- R4: With cc_lo = 0 and cc_hi = 1, the block behaves as a plain adder with carry-in seg_cin.
- R5: seg_cout is bit WIDTH of the selected sum, taken from the same speculative adder as seg_sum.
- R6: All-ones operands with an effective carry of 1 produce a sum of all ones and a carry-out of 1. All-ones plus zero with an effective carry of 1 produces a sum of zero and a carry-out of 1.
- R7: With SEL_MODE = SEL_TIED0, the outputs equal opa + opb, whatever seg_cin, cc_lo and cc_hi are.
- R8: With SEL_MODE = SEL_TIED1, the outputs equal opa + opb + 1, whatever seg_cin, cc_lo and cc_hi are.
- R9: seg_sum[0] equals opa[0] XOR opb[0] XOR k, with k the effective carry of R1.
- R10: R1 holds for WIDTH values of 2, 4, 8 and 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First operand slice |
| opb | input | WIDTH | Second operand slice |
| seg_cin | input | 1 | Carry into the lower slice; steers the decoder |
| cc_lo | input | 1 | Lower slice carry-out assuming its carry-in is 0 |
| cc_hi | input | 1 | Lower slice carry-out assuming its carry-in is 1 |
| seg_sum | output | WIDTH | Selected sum of this slice |
| seg_cout | output | 1 | Selected carry-out of this slice |

## Verification
At 2, 4 and 8 bits, every operand pair is applied under all eight combinations of seg_cin, cc_lo and cc_hi. This exposes any decoder row that picks the wrong adder, and any fault in the folded lowest bit that only appears for one assumed carry. The 16-bit width gets random operands mixed with all-ones, zero and alternating patterns; these drive a carry through the full ripple chain and separate a selection error from a bit-level adder error. The tied-select builds get the same vectors, which shows that the unused inputs cannot reach their outputs.

// File: rtl/csel_pkg.sv
package csel_pkg;

    // How the output select of a segment is obtained.
    typedef enum logic [1:0] {
        SEL_DYNAMIC = 2'd0,  // decoded from seg_cin, cc_lo, cc_hi
        SEL_TIED0   = 2'd1,  // carry into the slice is always 0
        SEL_TIED1   = 2'd2   // carry into the slice is always 1
    } sel_mode_e;

    // Majority of three: carry out of a full adder cell.
    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

    // Sum bit of a full adder cell.
    function automatic logic xor3(input logic x, input logic y, input logic z);
        return x ^ y ^ z;
    endfunction

endpackage

// File: rtl/csel_rca_fixed.sv
// Ripple-carry adder with a constant carry-in built into bit 0.
module csel_rca_fixed #(
    parameter int unsigned WIDTH   = 4,
    parameter bit          CIN_ONE = 1'b0
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    // chain[i] is the carry into bit i, for i >= 1
    logic [WIDTH:1] chain;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            if (i == 0) begin : g_lsb
                if (CIN_ONE) begin : g_one
                    // a + b + 1 at bit 0: sum = a ^ ~b, carry = a | b
                    assign sum[0]   = opa[0] ^ ~opb[0];
                    assign chain[1] = opa[0] | opb[0];
                end else begin : g_zero
                    // a + b + 0 at bit 0: half adder
                    assign sum[0]   = opa[0] ^ opb[0];
                    assign chain[1] = opa[0] & opb[0];
                end
            end else begin : g_upper
                assign sum[i]     = csel_pkg::xor3(opa[i], opb[i], chain[i]);
                assign chain[i+1] = csel_pkg::maj3(opa[i], opb[i], chain[i]);
            end
        end
    endgenerate

    assign cout = chain[WIDTH];
endmodule

// File: rtl/csel_sel_decode.sv
// Three-input select decoder: picks the carry-in-1 adder when the real
// carry into this slice is 1.
module csel_sel_decode (
    input  logic blk_cin,
    input  logic cc_lo,
    input  logic cc_hi,
    output logic pick_hi
);
    always_comb begin
        pick_hi = (~blk_cin & cc_lo) | (blk_cin & cc_hi);
    end
endmodule

// File: rtl/csel_segment.sv
module csel_segment
    import csel_pkg::*;
#(
    parameter int unsigned WIDTH    = 8,
    parameter sel_mode_e   SEL_MODE = SEL_DYNAMIC
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             seg_cin,
    input  logic             cc_lo,
    input  logic             cc_hi,
    output logic [WIDTH-1:0] seg_sum,
    output logic             seg_cout
);
    localparam int unsigned RW = WIDTH + 1;

    typedef struct packed {
        logic             cout;
        logic [WIDTH-1:0] sum;
    } seg_res_t;

    seg_res_t res_d;

    generate
        if (SEL_MODE == SEL_DYNAMIC) begin : g_dyn
            logic [WIDTH-1:0] sum_z, sum_o;
            logic             cout_z, cout_o;
            logic             pick_hi;

            csel_rca_fixed #(.WIDTH(WIDTH), .CIN_ONE(1'b0)) u_rca_z (
                .opa(opa), .opb(opb), .sum(sum_z), .cout(cout_z)
            );
            csel_rca_fixed #(.WIDTH(WIDTH), .CIN_ONE(1'b1)) u_rca_o (
                .opa(opa), .opb(opb), .sum(sum_o), .cout(cout_o)
            );
            csel_sel_decode u_dec (
                .blk_cin(seg_cin), .cc_lo(cc_lo), .cc_hi(cc_hi), .pick_hi(pick_hi)
            );

            always_comb begin
                res_d = pick_hi ? seg_res_t'({cout_o, sum_o})
                                : seg_res_t'({cout_z, sum_z});
            end
        end else begin : g_tied
            logic [WIDTH-1:0] sum_t;
            logic             cout_t;
            logic             unused_sel_inputs;

            csel_rca_fixed #(
                .WIDTH  (WIDTH),
                .CIN_ONE(SEL_MODE == SEL_TIED1)
            ) u_rca_t (
                .opa(opa), .opb(opb), .sum(sum_t), .cout(cout_t)
            );

            assign unused_sel_inputs = ^{seg_cin, cc_lo, cc_hi};

            always_comb begin
                res_d = seg_res_t'({cout_t, sum_t});
            end
        end
    endgenerate

    logic [RW-1:0] flat_d;
    always_comb begin
        flat_d   = res_d;
        seg_sum  = flat_d[WIDTH-1:0];
        seg_cout = flat_d[WIDTH];
    end
endmodule

// File: rtl/csel_segment_chk.sv
module csel_segment_chk
    import csel_pkg::*;
#(
    parameter int unsigned WIDTH    = 8,
    parameter sel_mode_e   SEL_MODE = SEL_DYNAMIC
) (
    input logic [WIDTH-1:0] opa,
    input logic [WIDTH-1:0] opb,
    input logic             seg_cin,
    input logic             cc_lo,
    input logic             cc_hi,
    input logic [WIDTH-1:0] seg_sum,
    input logic             seg_cout
);
    localparam int unsigned RW = WIDTH + 1;

    logic [RW-1:0] got;
    logic [RW-1:0] base;
    logic          k;

    always_comb begin
        got  = {seg_cout, seg_sum};
        base = RW'(opa) + RW'(opb);
        k    = seg_cin ? cc_hi : cc_lo;
        if (SEL_MODE == SEL_DYNAMIC) begin
            // R1, R10
            a_r1_selected_sum: assert (got == base + RW'(k));
            if (!seg_cin) begin
                a_r2_lo_path: assert (got == base + RW'(cc_lo));
            end else begin
                a_r3_hi_path: assert (got == base + RW'(cc_hi));
            end
            a_r9_lsb_folded: assert (seg_sum[0] == (opa[0] ^ opb[0] ^ k));
        end else if (SEL_MODE == SEL_TIED0) begin
            a_r7_tied_zero: assert (got == base);
        end else begin
            a_r8_tied_one: assert (got == base + RW'(1'b1));
        end
    end
endmodule

bind csel_segment csel_segment_chk #(
    .WIDTH   (WIDTH),
    .SEL_MODE(SEL_MODE)
) u_chk (
    .opa     (opa),
    .opb     (opb),
    .seg_cin (seg_cin),
    .cc_lo   (cc_lo),
    .cc_hi   (cc_hi),
    .seg_sum (seg_sum),
    .seg_cout(seg_cout)
);

// File: tb/csel_segment_test.sv
`timescale 1ns/100ps
module csel_segment_test;
    import csel_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    logic [15:0] va, vb;
    logic        vcin, vlo, vhi;

    logic [7:0]  s8;  logic c8;
    logic [1:0]  s2;  logic c2;
    logic [3:0]  s4;  logic c4;
    logic [15:0] s16; logic c16;
    logic [3:0]  st0; logic ct0;
    logic [3:0]  st1; logic ct1;

    csel_segment #(.WIDTH(8)) uut (
        .opa(va[7:0]), .opb(vb[7:0]), .seg_cin(vcin), .cc_lo(vlo), .cc_hi(vhi),
        .seg_sum(s8), .seg_cout(c8));
    csel_segment #(.WIDTH(2)) u_w2 (
        .opa(va[1:0]), .opb(vb[1:0]), .seg_cin(vcin), .cc_lo(vlo), .cc_hi(vhi),
        .seg_sum(s2), .seg_cout(c2));
    csel_segment #(.WIDTH(4)) u_w4 (
        .opa(va[3:0]), .opb(vb[3:0]), .seg_cin(vcin), .cc_lo(vlo), .cc_hi(vhi),
        .seg_sum(s4), .seg_cout(c4));
    csel_segment #(.WIDTH(16)) u_w16 (
        .opa(va), .opb(vb), .seg_cin(vcin), .cc_lo(vlo), .cc_hi(vhi),
        .seg_sum(s16), .seg_cout(c16));
    csel_segment #(.WIDTH(4), .SEL_MODE(SEL_TIED0)) u_t0 (
        .opa(va[3:0]), .opb(vb[3:0]), .seg_cin(vcin), .cc_lo(vlo), .cc_hi(vhi),
        .seg_sum(st0), .seg_cout(ct0));
    csel_segment #(.WIDTH(4), .SEL_MODE(SEL_TIED1)) u_t1 (
        .opa(va[3:0]), .opb(vb[3:0]), .seg_cin(vcin), .cc_lo(vlo), .cc_hi(vhi),
        .seg_sum(st1), .seg_cout(ct1));

    // Reference: w-bit slice sum with carry k, carry-out at bit w.
    function automatic int ref_add(int w, logic [15:0] a, logic [15:0] b, logic k);
        int m = (1 << w) - 1;
        return (int'(a) & m) + (int'(b) & m) + int'(k);
    endfunction

    function automatic int pack_out(int w, logic [15:0] s, logic c);
        return int'(s) + (int'(c) << w);
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0h exp %0h (a=%h b=%h cin=%b lo=%b hi=%b)",
                     tag, got, exp, va, vb, vcin, vlo, vhi);
        end
    endtask

    // Apply one vector, wait for settle, compare every instance.
    task automatic apply(input logic [15:0] a, input logic [15:0] b,
                         input logic ci, input logic lo, input logic hi);
        logic k;
        va = a; vb = b; vcin = ci; vlo = lo; vhi = hi;
        #1;
        k = ci ? hi : lo;
        if (!lo && hi) check("R4", pack_out(8, 16'(s8), c8), ref_add(8, a, b, k));
        else           check("R1", pack_out(8, 16'(s8), c8), ref_add(8, a, b, k));
        check("R5", int'(c8), (ref_add(8, a, b, k) >> 8) & 1);
        check("R9", int'(s8[0]), int'(a[0] ^ b[0] ^ k));
        check("R10", pack_out(2, 16'(s2), c2), ref_add(2, a, b, k));
        check("R10", pack_out(4, 16'(s4), c4), ref_add(4, a, b, k));
        check("R10", pack_out(16, s16, c16), ref_add(16, a, b, k));
        check("R7", pack_out(4, 16'(st0), ct0), ref_add(4, a, b, 1'b0));
        check("R8", pack_out(4, 16'(st1), ct1), ref_add(4, a, b, 1'b1));
        #1;
    endtask

    initial begin
        va = '0; vb = '0; vcin = 1'b0; vlo = 1'b0; vhi = 1'b0;
        #2;
        // Idle state: zero inputs give zero outputs
        check("R1", pack_out(8, 16'(s8), c8), 0);
        #1;

        // R2: seg_cin = 0, toggling cc_hi must not move the result
        apply(16'h00F0, 16'h000F, 1'b0, 1'b1, 1'b0);
        check("R2", pack_out(8, 16'(s8), c8), 16'h100);
        apply(16'h00F0, 16'h000F, 1'b0, 1'b1, 1'b1);
        check("R2", pack_out(8, 16'(s8), c8), 16'h100);
        // R3: seg_cin = 1, toggling cc_lo must not move the result
        apply(16'h0055, 16'h00AA, 1'b1, 1'b0, 1'b1);
        check("R3", pack_out(8, 16'(s8), c8), 16'h100);
        apply(16'h0055, 16'h00AA, 1'b1, 1'b1, 1'b1);
        check("R3", pack_out(8, 16'(s8), c8), 16'h100);
        apply(16'h0055, 16'h00AA, 1'b1, 1'b1, 1'b0);
        check("R3", pack_out(8, 16'(s8), c8), 16'h0FF);
        // R6: full carry propagation
        apply(16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b1);
        check("R6", pack_out(16, s16, c16), 32'h1FFFF);
        apply(16'hFFFF, 16'h0000, 1'b0, 1'b1, 1'b0);
        check("R6", pack_out(16, s16, c16), 32'h10000);
        check("R6", pack_out(8, 16'(s8), c8), 32'h100);

        // Exhaustive over 8-bit operands and all select inputs
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                for (int m = 0; m < 8; m++) begin
                    apply(16'(a), 16'(b), m[0], m[1], m[2]);
                end
            end
        end

        // Random 16-bit vectors, fixed seed
        void'($urandom(32'h5EED_0123));
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r = $urandom;
            apply(16'($urandom), 16'($urandom), r[0], r[1], r[2]);
        end
        apply(16'hAAAA, 16'h5555, 1'b0, 1'b1, 1'b1);
        apply(16'h8000, 16'h8000, 1'b1, 1'b0, 1'b0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule